// File: doc/BRIEF.md
# Selectable Host Clock Output Generator

This block supplies a clock to an external microcontroller over a pin that is otherwise used for general-purpose interface data. It runs from a 100 MHz reference clock. A 2-bit strap code is captured while reset is held. After reset is released, that code either leaves the pin to the interface or replaces the interface signal with the reference clock divided by 4, 5 or 10. These divisions give 25, 20 and 10 MHz.

The code is captured once, in the last reference cycle of reset, and is held from then on. The divider therefore never changes ratio while it runs, and it needs no glitch-free switching. The pin value and the pin output enable are both registered.

Top module: `hostclk_gen`

## Requirements
- R1: With strap code 0, `pin_o` and `pin_oe_o` copy `gp_data_i` and `gp_oe_i` one clock edge later.
- R2: With strap code 1, `pin_o` repeats every 4 cycles as 2 cycles high and then 2 cycles low. Counting edges after reset release as k = 1, 2, ..., the output is 0 after edge 1 and is high after edge k when (k-2) mod 4 < 2.
- R3: With strap code 2, `pin_o` repeats every 5 cycles as 2 cycles high and then 3 cycles low. The output is high after edge k (k ≥ 2) when (k-2) mod 5 < 2.
- R4: With strap code 3, `pin_o` repeats every 10 cycles as 5 cycles high and then 5 cycles low. The output is high after edge k (k ≥ 2) when (k-2) mod 10 < 5.
- R5: With any non-zero strap code, `pin_oe_o` is 1 from edge 1 on, and `gp_data_i` and `gp_oe_i` have no effect on either output.
- R6: The strap code is taken from `mode_i` on the last edge at which `rst` is high. Changes to `mode_i` after reset release have no effect until the next reset.
- R7: While `rst` is high, `pin_o` and `pin_oe_o` are 0 after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Strap code, captured during reset |
| gp_data_i | input | 1 | Interface data for the shared pin |
| gp_oe_i | input | 1 | Interface output enable for the shared pin |
| pin_o | output | 1 | Registered value of the shared pin |
| pin_oe_o | output | 1 | Registered output enable of the shared pin |

## Verification
In pass-through mode, each output shows the interface inputs from the previous edge. The bench drives those inputs between edges and compares them after the next edge. In clock modes the divider stage and the pin register add two edges in series, so the first high level appears after the second edge following reset release. The bench counts edges from release and checks every cycle against a modulo formula. Strap and interface inputs are randomized after release in all modes, so any effect of the ignored inputs shows up in the same per-edge comparison.

// File: rtl/hostclk_pkg.sv
package hostclk_pkg;
  typedef enum logic [1:0] {
    CK_OFF  = 2'd0,
    CK_FAST = 2'd1,
    CK_MID  = 2'd2,
    CK_SLOW = 2'd3
  } ck_mode_t;
endpackage

// File: rtl/hostclk_strap.sv
module hostclk_strap
  import hostclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic [1:0] code_i,
  output ck_mode_t code_o
);
  ck_mode_t code_q;

  // capture continuously while in reset, freeze afterwards
  always_ff @(posedge clk) begin
    if (rst) code_q <= ck_mode_t'(code_i);
  end

  assign code_o = code_q;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(code_q)); // R6
endmodule

// File: rtl/hostclk_div.sv
module hostclk_div
  import hostclk_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 5,
  parameter int DIV_SLOW = 10
) (
  input  logic     clk,
  input  logic     rst,
  input  ck_mode_t code_i,
  output logic     tick_o
);
  localparam int MAXD = (DIV_FAST > DIV_MID) ?
                        ((DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW) :
                        ((DIV_MID > DIV_SLOW) ? DIV_MID : DIV_SLOW);
  localparam int CW = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q, last_c, hi_c;
  logic          run_c, clk_q;

  always_comb begin
    run_c  = 1'b1;
    last_c = '0;
    hi_c   = '0;
    case (code_i)
      CK_FAST: begin last_c = CW'(DIV_FAST - 1); hi_c = CW'(DIV_FAST / 2); end
      CK_MID:  begin last_c = CW'(DIV_MID - 1);  hi_c = CW'(DIV_MID / 2);  end
      CK_SLOW: begin last_c = CW'(DIV_SLOW - 1); hi_c = CW'(DIV_SLOW / 2); end
      default: run_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run_c) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == last_c) ? '0 : cnt_q + 1'b1;
      clk_q <= (cnt_q < hi_c);
    end
  end

  assign tick_o = clk_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_c); // R4
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (run_c && cnt_q == '0 && !$past(rst)) |-> !clk_q); // R2
  AST_RISE_AT_ONE: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_q) |-> (cnt_q == CW'(1))); // R3
endmodule

// File: rtl/hostclk_pinmux.sv
module hostclk_pinmux
  import hostclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ck_mode_t code_i,
  input  logic     tick_i,
  input  logic     gp_data_i,
  input  logic     gp_oe_i,
  output logic     pin_o,
  output logic     pin_oe_o
);
  logic pin_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (code_i != CK_OFF) begin
      pin_q <= tick_i;
      oe_q  <= 1'b1;
    end else begin
      pin_q <= gp_data_i;
      oe_q  <= gp_oe_i;
    end
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = oe_q;

  AST_OE_IN_CLK: assert property (@(posedge clk) disable iff (rst)
    (code_i != CK_OFF) |=> oe_q); // R5
endmodule

// File: rtl/hostclk_gen.sv
module hostclk_gen
  import hostclk_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 5,
  parameter int DIV_SLOW = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       gp_data_i,
  input  logic       gp_oe_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  ck_mode_t code;
  logic     tick;

  hostclk_strap u_strap (
    .clk(clk), .rst(rst), .code_i(mode_i), .code_o(code)
  );

  hostclk_div #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_div (
    .clk(clk), .rst(rst), .code_i(code), .tick_o(tick)
  );

  hostclk_pinmux u_mux (
    .clk(clk), .rst(rst), .code_i(code), .tick_i(tick),
    .gp_data_i(gp_data_i), .gp_oe_i(gp_oe_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );
endmodule

// File: tb/sim_hostclk_gen.sv
module sim_hostclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic       gp_data_i = 1'b0;
  logic       gp_oe_i = 1'b0;
  logic       pin_o, pin_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hostclk_gen u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .gp_data_i(gp_data_i),
    .gp_oe_i(gp_oe_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  function automatic int div_of(input logic [1:0] m);
    case (m)
      2'd1: return 4;
      2'd2: return 5;
      default: return 10;
    endcase
  endfunction

  function automatic logic exp_clk(input logic [1:0] m, input int k);
    int n;
    n = div_of(m);
    if (k < 2) return 1'b0;
    return (((k - 2) % n) < (n / 2));
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_mode(input logic [1:0] m, input int cycles, input bit scramble);
    logic d_prev, oe_prev;
    @(negedge clk);
    rst = 1'b1;
    mode_i = m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", pin_o, 1'b0);
    check("R7", pin_oe_o, 1'b0);
    rst = 1'b0;
    d_prev = $urandom_range(0, 1);
    oe_prev = $urandom_range(0, 1);
    gp_data_i = d_prev;
    gp_oe_i = oe_prev;
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (m == 2'd0) begin
        check("R1", pin_o, d_prev);
        check("R1", pin_oe_o, oe_prev);
      end else begin
        check(req_of(m), pin_o, exp_clk(m, k));
        check("R5", pin_oe_o, 1'b1);
      end
      d_prev = $urandom_range(0, 1);
      oe_prev = $urandom_range(0, 1);
      gp_data_i = d_prev;
      gp_oe_i = oe_prev;
      // R6: strap changes after release must be ignored
      if (scramble) mode_i = 2'($urandom_range(0, 3));
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    // directed: every mode, strap steady, then strap scrambled (R6)
    for (int m = 0; m < 4; m++) run_mode(2'(m), 25, 1'b0);
    for (int m = 0; m < 4; m++) run_mode(2'(m), 25, 1'b1);
    // constrained random sequence of modes and run lengths
    for (int i = 0; i < 12; i++)
      run_mode(2'($urandom_range(0, 3)), $urandom_range(3, 40), 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule